// File: doc/BRIEF.md
# Key-Driven Reversible Bit-Operation Unit

A purely combinational unit that turns one data word into one result word under the control of a sub-key word of the same width. Three bits picked out of the sub-key choose one of eight bit-balanced operations. A further group of sub-key bits gives a rotation amount. The eight operations are: XOR with the key, XNOR with the key, invert, pass-through, rotate right, rotate left, half swap and full bit reversal.

A single mode input selects encryption or decryption. Decryption swaps the two rotation directions and leaves the other six operations as they are, because each of those undoes itself. Feeding a result back with the same sub-key and the decrypt mode set therefore returns the original word. The positions of the selector bits inside the sub-key are parameters, so a cipher round can place them wherever its key schedule suits.

Top module: `keyop_unit`

## Requirements
- R1: The operation code is {key[OP_HI], key[OP_MID], key[OP_LO]}, with OP_HI as the MSB (default bits 7, 5, 3). Rotation amount bit i is key[ROT_MAP[8*i+:8]] (default: amount = {key[1], key[0], key[4]}, key[1] as the MSB). The amount is log2(W) bits wide.
- R2: Code 000 gives data XOR key, and code 100 gives data XNOR key.
- R3: Code 001 gives the inverted data, and code 011 gives the data unchanged.
- R4: In encrypt mode (decrypt_i=0), code 010 rotates right by the amount (result[i] = data[(i+amt) mod W]), and code 110 rotates left by the amount (result[i] = data[(i-amt) mod W]).
- R5: A rotation amount of 0 leaves the word unchanged under either rotation code, in either mode.
- R6: Code 101 exchanges the upper and lower halves of the word (result[i] = data[(i+W/2) mod W]), and code 111 reverses the bit order (result[i] = data[W-1-i]).
- R7: With decrypt_i=1, the two rotation codes rotate in the opposite direction and all other codes behave as in encrypt mode. Decrypting an encrypted word with the same key returns the original word.
- R8: The result depends on the present inputs alone. It has no clock and no stored state, and it follows an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | W | Word to transform |
| key_i | input | W | Sub-key: the operand for XOR/XNOR and the source of the selector bits |
| decrypt_i | input | 1 | 0 = encrypt, 1 = decrypt (rotation directions exchanged) |
| result_o | output | W | Transformed word |

## Verification
The bench builds the unit twice. The first copy uses the default 8-bit width with operation bits 7, 5, 3 and rotation bits 1, 0, 4. The second copy is 16 bits wide, with operation bits 15, 9, 2 and a four-bit amount taken from key bits 12, 6, 3, 0. The 16-bit copy reaches rotation amounts up to 15 and a selector layout that is neither contiguous nor ordered, so an error in bit placement or in modular index wraparound shows up there even when the 8-bit copy hides it. Both copies are driven with random words and keys and checked against an independent model, and then put through a decrypt round trip.

// File: rtl/keyop_unit.sv
module keyop_unit #(
  parameter int W      = 8,
  parameter int OP_HI  = 7,
  parameter int OP_MID = 5,
  parameter int OP_LO  = 3,
  parameter logic [8*$clog2(W)-1:0] ROT_MAP = 24'h01_00_04
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] key_i,
  input  logic         decrypt_i,
  output logic [W-1:0] result_o
);
  localparam int RB   = $clog2(W);
  localparam int HALF = W / 2;

  logic [2:0]    op;
  logic [RB-1:0] amt;
  logic [W-1:0]  rot_r, rot_l, swapped, reversed;
  logic          go_right;

  assign op = {key_i[OP_HI], key_i[OP_MID], key_i[OP_LO]};

  for (genvar b = 0; b < RB; b++) begin : g_amt
    localparam int POS = int'(ROT_MAP[8*b +: 8]);
    assign amt[b] = key_i[POS];
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [RB-1:0] src_r, src_l;
    assign src_r       = RB'(i) + amt;
    assign src_l       = RB'(i) - amt;
    assign rot_r[i]    = data_i[src_r];
    assign rot_l[i]    = data_i[src_l];
    assign swapped[i]  = data_i[(i + HALF) % W];
    assign reversed[i] = data_i[W-1-i];
  end

  assign go_right = (op == 3'b010) ^ decrypt_i;

  always_comb begin
    unique case (op)
      3'b000:         result_o = data_i ^ key_i;
      3'b001:         result_o = ~data_i;
      3'b011:         result_o = data_i;
      3'b100:         result_o = ~(data_i ^ key_i);
      3'b101:         result_o = swapped;
      3'b111:         result_o = reversed;
      default:        result_o = go_right ? rot_r : rot_l;
    endcase
  end

  always_comb begin
    if (!$isunknown({data_i, key_i, decrypt_i})) begin
      a_r2_xor_key:  assert (op != 3'b000 || (result_o ^ data_i) == key_i);
      a_r2_xnor_key: assert (op != 3'b100 || (result_o ^ data_i) == ~key_i);
      a_r3_invert:   assert (op != 3'b001 || ((result_o & data_i) == '0 && (result_o | data_i) == '1));
      a_r3_pass:     assert (op != 3'b011 || result_o == data_i);
      a_r5_zero_rot: assert (!(op[1:0] == 2'b10 && amt == '0) || result_o == data_i);
      a_r6_rev_ends: assert (op != 3'b111 || (result_o[W-1] == data_i[0] && result_o[0] == data_i[W-1]));
      a_r4_balanced: assert (!(op == 3'b010 || op[2:1] == 2'b11 || op == 3'b101)
                             || $countones(result_o) == $countones(data_i));
    end
  end
endmodule

// File: tb/keyop_unit_tb.sv
module keyop_unit_tb;
  localparam int PERIOD = 10;
  localparam int NVEC   = 14;
  localparam int NRAND  = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0]  d8, k8, r8;
  logic        m8;
  logic [15:0] d16, k16, r16;
  logic        m16;

  keyop_unit u_dut (.data_i(d8), .key_i(k8), .decrypt_i(m8), .result_o(r8));

  keyop_unit #(.W(16), .OP_HI(15), .OP_MID(9), .OP_LO(2), .ROT_MAP(32'h0C_06_03_00)) u_dut16 (
    .data_i(d16), .key_i(k16), .decrypt_i(m16), .result_o(r16));

  // {req, decrypt, key, data, expected}
  localparam logic [28:0] VEC [NVEC] = '{
    {4'd2, 1'b0, 8'h13, 8'hA5, 8'hB6},  // R2 xor
    {4'd2, 1'b0, 8'h86, 8'h0F, 8'h76},  // R2 xnor
    {4'd3, 1'b0, 8'h08, 8'h3C, 8'hC3},  // R3 invert
    {4'd3, 1'b0, 8'h2B, 8'h5A, 8'h5A},  // R3 pass
    {4'd4, 1'b0, 8'h31, 8'h81, 8'h30},  // R4 ror 3
    {4'd4, 1'b0, 8'hB0, 8'h81, 8'h03},  // R4 rol 1
    {4'd4, 1'b0, 8'hB3, 8'h01, 8'h80},  // R4 rol 7
    {4'd5, 1'b0, 8'h20, 8'h6D, 8'h6D},  // R5 ror 0
    {4'd5, 1'b1, 8'hA0, 8'h6D, 8'h6D},  // R5 rol 0 decrypt
    {4'd6, 1'b0, 8'h88, 8'h1E, 8'hE1},  // R6 half swap
    {4'd6, 1'b0, 8'hA8, 8'h35, 8'hAC},  // R6 reverse
    {4'd7, 1'b1, 8'h31, 8'h30, 8'h81},  // R7 undo ror
    {4'd7, 1'b1, 8'hB0, 8'h03, 8'h81},  // R7 undo rol
    {4'd7, 1'b1, 8'h13, 8'hB6, 8'hA5}   // R7 xor unchanged
  };

  function automatic logic [15:0] model(int w, logic [15:0] d, logic [15:0] k,
                                        logic [2:0] op, int amt, bit dec);
    logic [15:0] r = '0;
    int a = (((op == 3'b010) ^ dec) != 0) ? amt : (w - amt) % w;
    for (int i = 0; i < w; i++) begin
      case (op)
        3'b000: r[i] = d[i] ^ k[i];
        3'b001: r[i] = ~d[i];
        3'b011: r[i] = d[i];
        3'b100: r[i] = ~(d[i] ^ k[i]);
        3'b101: r[i] = d[(i + w/2) % w];
        3'b111: r[i] = d[w-1-i];
        default: r[i] = d[(i + a) % w];
      endcase
    end
    return r;
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    d8 = '0; k8 = '0; m8 = 1'b0; d16 = '0; k16 = '0; m16 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R6 R7: directed 8-bit vectors
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      {m8, k8, d8} = VEC[v][24:8];
      #1;
      check($sformatf("R%0d vec%0d", VEC[v][28:25], v), {8'h0, r8}, {8'h0, VEC[v][7:0]});
    end

    // R8: output follows inputs between clock edges
    @(posedge clk); #1;
    m8 = 1'b0; k8 = 8'h08; d8 = 8'hF0; #1;
    check("R8 no-edge invert", {8'h0, r8}, 16'h000F);
    d8 = 8'h55; #1;
    check("R8 no-edge update", {8'h0, r8}, 16'h00AA);

    // R1 R7: random sweep over every code, 8 bits
    for (int n = 0; n < NRAND; n++) begin
      logic [7:0] p, c;
      logic [2:0] op;
      int amt;
      @(negedge clk);
      p = 8'($urandom); k8 = 8'($urandom);
      k8[7] = n[2]; k8[5] = n[1]; k8[3] = n[0];
      op = {k8[7], k8[5], k8[3]}; amt = {k8[1], k8[0], k8[4]};
      m8 = 1'b0; d8 = p; #1;
      c = r8;
      check("R1 enc8 model", {8'h0, c}, model(8, {8'h0, p}, {8'h0, k8}, op, amt, 1'b0));
      m8 = 1'b1; d8 = c; #1;
      check("R7 roundtrip8", {8'h0, r8}, {8'h0, p});
    end

    // R1 R4 R7: random sweep, 16 bits with scattered selector bits
    for (int n = 0; n < NRAND; n++) begin
      logic [15:0] p, c;
      logic [2:0] op;
      int amt;
      @(negedge clk);
      p = 16'($urandom); k16 = 16'($urandom);
      k16[15] = n[2]; k16[9] = n[1]; k16[2] = n[0];
      op = {k16[15], k16[9], k16[2]}; amt = {k16[12], k16[6], k16[3], k16[0]};
      m16 = 1'b0; d16 = p; #1;
      c = r16;
      check("R1 enc16 model", c, model(16, p, k16, op, amt, 1'b0));
      m16 = 1'b1; d16 = c; #1;
      check("R7 roundtrip16", r16, p);
      check("R7 dec16 model", r16, model(16, c, k16, op, amt, 1'b1));
    end

    // R4: 16-bit rotate right by 15 (amount bits 12,6,3,0 all set, code 010 -> bit 9)
    @(negedge clk);
    m16 = 1'b0; k16 = 16'h1249; d16 = 16'h0001; #1;
    check("R4 ror15 16b", r16, 16'h0002);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule